// File: doc/BRIEF.md
# Horizontal Reference Reacquisition Lock Controller

This block keeps a local line counter running beside an incoming horizontal sync reference. It notices when the reference disappears. When pulses come back, it watches them over a run of lines and then picks one of two ways to lock. In a drift lock the output line timing is left untouched and the downstream loop pulls it in slowly. In a crash lock the output line counter is snapped onto the phase of the returning reference.

Once locked, the block can ride through one absent reference pulse (flywheeling) if the configuration input allows it. A software strobe restarts only the line counter. All other state is left as it was.

Top module: `href_reacq_lock`

## Requirements
- R1: After reset the lock mode reads 2'b00, both the reference-lost and lock-lost flags read 1, and the line phase reads 0.
- R2: The line phase counts up by one per clock from 0 to LINE_LEN-1 and wraps to 0. The output H pulse is high exactly while the phase is 0.
- R3: A reference pulse counts as inside the window when the phase at its arrival is at most WIN or at least LINE_LEN-WIN. WIN is CLK_HZ/500000 clocks, which is 2 us.
- R4: A reference pulse seen while the mode is 2'b00 moves the mode to 2'b01 (checking) on the next cycle. The decision is taken on the CHECK_LINES-th pulse (16 by default). Before that pulse the mode stays 2'b01.
- R5: If every checked pulse is inside the window, then on the cycle after the deciding pulse the mode is 2'b10 (drift) and both flags are 0. The line phase continues without any jump.
- R6: If any checked pulse is outside the window, then on the cycle after the deciding pulse reference-lost is 0, lock-lost stays 1 and the mode stays 2'b01. On the cycle after the next reference pulse the phase is 0, the mode is 2'b11 (crash) and lock-lost is 0.
- R7: While locked (mode 2'b10 or 2'b11), a window closes each time the phase reads WIN. With flywheeling enabled, two consecutive closes with no in-window pulse make the mode 2'b00 and set both flags to 1, from the cycle after the second close.
- R8: With flywheeling enabled, a single missed window leaves the mode and flags unchanged, and the output H pulse keeps firing through the gap.
- R9: With flywheeling disabled, a single missed window while locked makes the mode 2'b00 and sets both flags to 1, from the cycle after that close.
- R10: While checking, if no reference pulse arrives for LINE_LEN+WIN cycles after the last one, the mode returns to 2'b00 and both flags read 1. This is seen LINE_LEN+WIN+1 cycles after the cycle in which the last pulse was presented.
- R11: A line-reset strobe makes the phase read 0 on the next cycle and leaves the mode and both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_h_i | input | 1 | Reference H pulse, one cycle wide |
| flywheel_en_i | input | 1 | 1: tolerate one missed pulse while locked |
| line_rst_i | input | 1 | Software strobe that restarts the line counter |
| h_out_o | output | 1 | Output H pulse |
| line_phase_o | output | $clog2(LINE_LEN) | Line counter phase |
| ref_lost_o | output | 1 | Reference absent or not yet reacquired |
| lock_lost_o | output | 1 | Output timing not locked |
| lock_mode_o | output | 2 | 00 unlocked, 01 checking, 10 drift locked, 11 crash realigned |

## Verification
A pulse presented in cycle c lands at the clock edge that ends that cycle. Its effect on the mode, the flags and a realigned phase is therefore visible in cycle c+1. A window close is taken while the phase reads WIN, so a resulting loss of lock shows one cycle after that phase value. The checking timeout shows LINE_LEN+WIN+1 cycles after the last pulse. The bench keeps its own cycle count and a model of the phase. It queues each expectation against the exact cycle in which it falls due, and compares on the falling edge of that cycle.

// File: rtl/hrl_pkg.sv
// Package: shared types and derived constants for the reacquisition lock controller.
// Assumes: the window half-width is 2 us, so it is the clock rate divided by 500000.
package hrl_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_CHECK = 2'b01,
        MODE_DRIFT = 2'b10,
        MODE_CRASH = 2'b11
    } lock_mode_e;

    // Window half-width in clocks for a given clock rate.
    function automatic int win_cycles(input int clk_hz);
        return clk_hz / 500_000;
    endfunction

endpackage

// File: rtl/hrl_line_timer.sv
// Module: free-running line phase counter with output H pulse and window decode.
// Assumes: WIN is below LINE_LEN/2; load_i restarts the phase at 0 on the next cycle.
module hrl_line_timer #(
    parameter int LINE_LEN = 1716,
    parameter int WIN      = 54
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    output logic [$clog2(LINE_LEN)-1:0] phase_o,
    output logic                        hsync_o,
    output logic                        in_win_o,
    output logic                        win_close_o
);
    localparam int PW = $clog2(LINE_LEN);
    localparam logic [PW-1:0] LAST_P = PW'(LINE_LEN - 1);
    localparam logic [PW-1:0] WIN_P  = PW'(WIN);
    localparam logic [PW-1:0] LOW_P  = PW'(LINE_LEN - WIN);

    logic [PW-1:0] phase_q;

    // Advance the phase each clock, wrapping at the line end or restarting on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (load_i || phase_q == LAST_P) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PW'(1);
        end
    end

    // Decode the output pulse, the tolerance window and its closing point.
    always_comb begin
        hsync_o     = (phase_q == '0);
        in_win_o    = (phase_q <= WIN_P) || (phase_q >= LOW_P);
        win_close_o = (phase_q == WIN_P);
    end

    assign phase_o = phase_q;

    AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> phase_q == '0); // R6
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST_P); // R2

endmodule

// File: rtl/hrl_miss_tracker.sv
// Module: counts missed reference windows while locked and flags a loss of reference.
// Assumes: one close per line; set_seen_i marks the current window as hit (after realignment).
module hrl_miss_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic locked_i,
    input  logic fly_i,
    input  logic ref_h_i,
    input  logic in_win_i,
    input  logic win_close_i,
    input  logic set_seen_i,
    output logic lost_o
);
    logic seen_q;
    logic miss_q;
    logic hit;

    // A window is hit if a pulse fell inside it earlier or arrives now.
    always_comb begin
        hit    = seen_q || (ref_h_i && in_win_i);
        lost_o = locked_i && win_close_i && !hit && (!fly_i || miss_q);
    end

    // Remember an in-window pulse until the window closes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (set_seen_i) begin
            seen_q <= 1'b1;
        end else if (win_close_i) begin
            seen_q <= 1'b0;
        end else if (ref_h_i && in_win_i) begin
            seen_q <= 1'b1;
        end
    end

    // Track one pending miss; clear on a hit or when not locked.
    always_ff @(posedge clk) begin
        if (!rst_n || !locked_i) begin
            miss_q <= 1'b0;
        end else if (win_close_i) begin
            miss_q <= !hit;
        end
    end

    AST_LOST_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        lost_o |-> win_close_i && locked_i); // R7
    AST_FLY_ONE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (fly_i && !miss_q) |-> !lost_o); // R8

endmodule

// File: rtl/hrl_acq_fsm.sv
// Module: acquisition sequencer; checks returning pulses over a run of lines,
// picks drift or crash lock, and drops back to unlocked on loss or timeout.
// Assumes: CHECK_LINES >= 2; ref_h_i pulses are one cycle wide.
module hrl_acq_fsm
    import hrl_pkg::*;
#(
    parameter int CHECK_LINES = 16,
    parameter int TMO         = 1770
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_h_i,
    input  logic       in_win_i,
    input  logic       lost_i,
    output logic       align_o,
    output logic       locked_o,
    output logic       ref_lost_o,
    output logic       lock_lost_o,
    output logic [1:0] mode_o
);
    localparam int CW = $clog2(CHECK_LINES + 1);
    localparam int GW = $clog2(TMO + 1);

    lock_mode_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          bad_q;
    logic          pend_q;
    logic          ref_lost_q;
    logic          lock_lost_q;
    logic [GW-1:0] gap_q;

    // Count cycles since the last reference pulse, saturating at the timeout.
    always_ff @(posedge clk) begin
        if (!rst_n || ref_h_i) begin
            gap_q <= '0;
        end else if (gap_q != GW'(TMO)) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    // Lock state, check counter, crash-pending flag and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= MODE_IDLE;
            cnt_q       <= '0;
            bad_q       <= 1'b0;
            pend_q      <= 1'b0;
            ref_lost_q  <= 1'b1;
            lock_lost_q <= 1'b1;
        end else begin
            case (state_q)
                MODE_IDLE: begin
                    if (ref_h_i) begin
                        state_q <= MODE_CHECK;
                        cnt_q   <= CW'(1);
                        bad_q   <= !in_win_i;
                        pend_q  <= 1'b0;
                    end
                end
                MODE_CHECK: begin
                    if (ref_h_i) begin
                        if (pend_q) begin
                            state_q     <= MODE_CRASH;
                            lock_lost_q <= 1'b0;
                            pend_q      <= 1'b0;
                        end else if (cnt_q == CW'(CHECK_LINES - 1)) begin
                            ref_lost_q <= 1'b0;
                            if (bad_q || !in_win_i) begin
                                pend_q <= 1'b1;
                            end else begin
                                state_q     <= MODE_DRIFT;
                                lock_lost_q <= 1'b0;
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                            bad_q <= bad_q || !in_win_i;
                        end
                    end else if (gap_q == GW'(TMO - 1)) begin
                        state_q     <= MODE_IDLE;
                        pend_q      <= 1'b0;
                        ref_lost_q  <= 1'b1;
                        lock_lost_q <= 1'b1;
                    end
                end
                default: begin
                    if (lost_i) begin
                        state_q     <= MODE_IDLE;
                        ref_lost_q  <= 1'b1;
                        lock_lost_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Expose the realign request, the locked indication and the status outputs.
    always_comb begin
        align_o     = (state_q == MODE_CHECK) && pend_q && ref_h_i;
        locked_o    = (state_q == MODE_DRIFT) || (state_q == MODE_CRASH);
        ref_lost_o  = ref_lost_q;
        lock_lost_o = lock_lost_q;
        mode_o      = state_q;
    end

    AST_LOCKED_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MODE_DRIFT || state_q == MODE_CRASH) |-> !ref_lost_q && !lock_lost_q); // R5
    AST_IDLE_FLAGS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == MODE_IDLE |-> ref_lost_q && lock_lost_q); // R1
    AST_CRASH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        align_o |=> state_q == MODE_CRASH && !lock_lost_q); // R6
    AST_CHECK_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == MODE_CHECK |-> lock_lost_q); // R4

endmodule

// File: rtl/href_reacq_lock.sv
// Module: top of the horizontal reference reacquisition lock controller.
// Assumes: one clock domain; ref_h_i is synchronous and one cycle wide; LINE_LEN > 2*WIN.
module href_reacq_lock
    import hrl_pkg::*;
#(
    parameter int CLK_HZ      = 27_000_000,
    parameter int LINE_LEN    = 1716,
    parameter int CHECK_LINES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ref_h_i,
    input  logic                        flywheel_en_i,
    input  logic                        line_rst_i,
    output logic                        h_out_o,
    output logic [$clog2(LINE_LEN)-1:0] line_phase_o,
    output logic                        ref_lost_o,
    output logic                        lock_lost_o,
    output logic [1:0]                  lock_mode_o
);
    localparam int WIN = win_cycles(CLK_HZ);
    localparam int TMO = LINE_LEN + WIN;

    logic align;
    logic locked;
    logic in_win;
    logic win_close;
    logic lost;
    logic load;

    // The counter restarts on a crash realignment or on the software strobe.
    assign load = align || line_rst_i;

    hrl_line_timer #(
        .LINE_LEN (LINE_LEN),
        .WIN      (WIN)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .phase_o     (line_phase_o),
        .hsync_o     (h_out_o),
        .in_win_o    (in_win),
        .win_close_o (win_close)
    );

    hrl_miss_tracker u_miss (
        .clk         (clk),
        .rst_n       (rst_n),
        .locked_i    (locked),
        .fly_i       (flywheel_en_i),
        .ref_h_i     (ref_h_i),
        .in_win_i    (in_win),
        .win_close_i (win_close),
        .set_seen_i  (align),
        .lost_o      (lost)
    );

    hrl_acq_fsm #(
        .CHECK_LINES (CHECK_LINES),
        .TMO         (TMO)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_h_i     (ref_h_i),
        .in_win_i    (in_win),
        .lost_i      (lost),
        .align_o     (align),
        .locked_o    (locked),
        .ref_lost_o  (ref_lost_o),
        .lock_lost_o (lock_lost_o),
        .mode_o      (lock_mode_o)
    );

    AST_STROBE_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_rst_i && !ref_h_i && !win_close) |=> $stable(lock_mode_o) && $stable(ref_lost_o)); // R11

endmodule

// File: tb/href_reacq_lock_bench.sv
// Bench: scoreboard of expectations keyed by cycle; a monitor compares on falling edges.
module href_reacq_lock_bench;
    localparam int CLK_PERIOD = 10;
    localparam int L   = 100;
    localparam int HZ  = 5_000_000;
    localparam int WIN = HZ / 500_000;
    localparam int TMO = L + WIN;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_h = 1'b0;
    logic       fly = 1'b1;
    logic       lrst = 1'b0;
    logic       h_out;
    logic [6:0] phase;
    logic       ref_lost;
    logic       lock_lost;
    logic [1:0] mode;

    int cyc = 0;
    int base = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        int    mode;
        int    rl;
        int    ll;
        int    ph;
        int    ho;
        string tag;
    } exp_t;
    exp_t sb[$];

    href_reacq_lock #(.CLK_HZ(HZ), .LINE_LEN(L), .CHECK_LINES(16)) u_href_reacq_lock (
        .clk           (clk),
        .rst_n         (rst_n),
        .ref_h_i       (ref_h),
        .flywheel_en_i (fly),
        .line_rst_i    (lrst),
        .h_out_o       (h_out),
        .line_phase_o  (phase),
        .ref_lost_o    (ref_lost),
        .lock_lost_o   (lock_lost),
        .lock_mode_o   (mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp_v, cyc);
        end
    endtask

    // Monitor: compare every expectation that falls due in this cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].at == cyc) begin
                    if (sb[i].mode >= 0) cmp(sb[i].tag, "mode", int'(mode), sb[i].mode);
                    if (sb[i].rl >= 0)   cmp(sb[i].tag, "ref_lost", int'(ref_lost), sb[i].rl);
                    if (sb[i].ll >= 0)   cmp(sb[i].tag, "lock_lost", int'(lock_lost), sb[i].ll);
                    if (sb[i].ph >= 0)   cmp(sb[i].tag, "phase", int'(phase), sb[i].ph);
                    if (sb[i].ho >= 0)   cmp(sb[i].tag, "h_out", int'(h_out), sb[i].ho);
                    sb.delete(i);
                end
            end
        end
    end

    task automatic expect_at(input int at, input int m, input int rl, input int ll,
                             input int ph, input int ho, input string tag);
        exp_t e;
        e.at = at; e.mode = m; e.rl = rl; e.ll = ll; e.ph = ph; e.ho = ho; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int mph();
        return (cyc - base) % L;
    endfunction

    task automatic pulse_at(input int p, output int c);
        while (mph() != p) tick();
        c = cyc;
        ref_h = 1'b1;
        tick();
        ref_h = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        int a;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state, R2 pulse at phase 0
        expect_at(0, 0, 1, 1, 0, 1, "R1 reset");
        expect_at(1, 0, 1, 1, 1, 0, "R2 count");

        // Drift acquisition with pulses on both window edges (R3, R4, R5)
        for (int i = 0; i < 16; i++) begin
            pulse_at((i % 2 == 0) ? WIN : L - WIN, c);
            if (i == 0)  expect_at(c + 1, 1, 1, 1, -1, -1, "R4 enter check");
            if (i == 14) expect_at(c + 1, 1, 1, 1, -1, -1, "R4 before last");
            if (i == 15) expect_at(c + 1, 2, 0, 0, (c + 1 - base) % L, -1, "R3/R5 drift lock");
        end

        // Single miss with flywheel (R8)
        pulse_at(3, c);
        pulse_at(3, c);
        expect_at(c + 97, 2, 0, 0, 0, 1, "R8 h_out in gap");
        expect_at(c + 108, 2, 0, 0, -1, -1, "R8 one miss tolerated");
        repeat (150) tick();
        pulse_at(3, c);
        pulse_at(3, c);

        // Two misses with flywheel (R7)
        expect_at(c + 108, 2, 0, 0, -1, -1, "R7 first miss");
        expect_at(c + 207, 2, 0, 0, -1, -1, "R7 before second close");
        expect_at(c + 208, 0, 1, 1, -1, -1, "R7 two misses");
        repeat (220) tick();

        // Crash acquisition, all lines out of window (R6)
        for (int i = 0; i < 16; i++) begin
            pulse_at(50, c);
            if (i == 15) expect_at(c + 1, 1, 0, 1, -1, -1, "R6 decide crash");
        end
        pulse_at(50, a);
        expect_at(a + 1, 3, 0, 0, 0, 1, "R6 realigned");
        expect_at(a + 2, 3, 0, 0, 1, 0, "R2 after realign");
        base = a + 1;

        // Flywheel off, single miss drops lock (R9)
        fly = 1'b0;
        pulse_at(L - 1, c);
        expect_at(c + 111, 3, 0, 0, -1, -1, "R9 before close");
        expect_at(c + 112, 0, 1, 1, -1, -1, "R9 single miss loss");
        repeat (130) tick();
        fly = 1'b1;

        // Checking timeout (R10)
        for (int i = 0; i < 3; i++) pulse_at(50, c);
        expect_at(c + TMO, 1, 1, 1, -1, -1, "R10 still checking");
        expect_at(c + TMO + 1, 0, 1, 1, -1, -1, "R10 timeout");
        repeat (TMO + 5) tick();

        // One bad line among sixteen forces crash (R3, R6)
        for (int i = 0; i < 15; i++) pulse_at(5, c);
        expect_at(c + 1, 1, 1, 1, -1, -1, "R4 fifteen pulses");
        pulse_at(WIN + 1, c);
        expect_at(c + 1, 1, 0, 1, -1, -1, "R3/R6 one bad line");
        pulse_at(60, a);
        expect_at(a + 1, 3, 0, 0, 0, 1, "R6 second realign");
        base = a + 1;

        // Software strobe (R11)
        while (mph() != 5) tick();
        expect_at(cyc + 1, 3, 0, 0, 0, 1, "R11 strobe phase");
        expect_at(cyc + 4, 3, 0, 0, 3, -1, "R11 state kept");
        lrst = 1'b1;
        tick();
        lrst = 1'b0;
        repeat (10) tick();

        foreach (sb[i]) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s: actual not-compared expected compare at cycle %0d", sb[i].tag, sb[i].at);
        end
        finish_run();
    end

endmodule